// File: doc/BRIEF.md
# Daisy-Chained Block-Read and Broadcast Bus Slave

This block is the slave side of a parallel backplane bus for a data board that keeps one event buffer. It serves plain addressed register cycles and also takes part in two crate-wide cycles that pass a token through a daisy chain. In the broadcast write cycle, every enabled slave treats the write as "move on to the next event". It clears its per-event status bits, steps its event counter and tells the event buffer to prefetch the first word of the new event. In the chained block read, the enabled slaves take turns placing their words for the current event on the data bus. Ownership moves to the next board when a slave has no words left. The board configured as the end of the chain closes the transfer with a bus error.

A master sees the chained read as an ordinary block read that ends with a bus error. It needs no knowledge of how much data each board holds. Each board's place in the chain comes from three configuration bits written through the register space.

The bus is modelled as synchronous, active-high signals sampled on `clk`. The data bus is split into a write-data input and a read-data output with an output enable.

Top module: `cblt_slave`

## Requirements
- R1: After reset, `dtack_o`, `berr_o` and `rdata_oe_o` are low, the configuration register reads 0, and `tok_out_o` equals `tok_in_i`.
- R2: Register cycles use address modifier 0x2F. They match on `addr_i[23:8]` == `CSR_PAGE`, with `addr_i[1:0]` = 0, and `addr_i[31:24]` is ignored. Offset `addr_i[7:2]`=0 is configuration, with bit0 enable, bit1 first and bit2 last. Offset 1 holds the status bits and offset 2 the event counter. Read data is zero-extended onto `rdata_o`. Any other modifier gets no acknowledge and changes nothing.
- R3: With the enable bit clear, chained and broadcast cycles get no acknowledge, no bus error and no buffer strobe, and `tok_out_o` mirrors `tok_in_i`.
- R4: In a chained read, a slave with the first bit set owns the token once the cycle is decoded. Any other slave answers no strobe until `tok_in_i` is high.
- R5: While it owns the token, each data strobe makes the slave put the current word on `rdata_o`, raise `rdata_oe_o` and `dtack_o`, and pulse `evt_pop_o` once. `dtack_o` drops after `ds_i` is removed.
- R6: Chained modifiers 0x0C and 0x08 return the full 64-bit word. Modifiers 0x0F and 0x0B return its low 32 bits with the upper half zero.
- R7: A slave that is not last raises `tok_out_o` and answers no further strobe in that cycle once its word count is 0. This happens after its final word, or at once when it owns the token with no words.
- R8: A slave with the last bit set answers a strobe with `berr_o`, and no `dtack_o`, once it owns the token with a word count of 0.
- R9: A broadcast write (modifier 0x09 or 0x0D, `addr_i[31:24]` == `BCAST_ADR`) pulses `evt_next_o` for one cycle on its data strobe. It clears the status bits and increments the event counter.
- R10: In a broadcast, only a slave with the last bit set raises `dtack_o`, and only after it owns the token. A slave that is not last raises `tok_out_o` and never acknowledges.
- R11: Dropping `as_i` clears `dtack_o`, `berr_o`, `rdata_oe_o` and the held token. A following chained cycle starts again from token acquisition.
- R12: A write to the chained address and a read from the broadcast address get no response, with no `evt_pop_o` and no `evt_next_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| as_i | input | 1 | Address strobe, high for the whole master cycle |
| ds_i | input | 1 | Data strobe, high per transferred word |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| am_i | input | 6 | Address modifier |
| addr_i | input | 32 | Bus address |
| wdata_i | input | 32 | Write data from the master |
| rdata_o | output | 64 | Read data driven to the bus |
| rdata_oe_o | output | 1 | Read data valid / bus drive enable |
| dtack_o | output | 1 | Data acknowledge |
| berr_o | output | 1 | Bus error, ends a chained read |
| tok_in_i | input | 1 | Token from the previous slave |
| tok_out_o | output | 1 | Token to the next slave |
| evt_word_i | input | 64 | Current event-buffer word |
| evt_words_i | input | WCNT_W | Words left in the current event |
| evt_pop_o | output | 1 | Consume the current word |
| evt_next_o | output | 1 | Advance to the next event and prefetch |
| stat_set_i | input | STAT_W | Board sets per-event status bits |
| stat_o | output | STAT_W | Per-event status bits |

## Verification
A state register that slips shows at the chain ports within one or two clocks. A slave that keeps the token too long gives an acknowledge where the next board should answer, or a second word after the count reached zero. One that lets go too early raises `tok_out_o` while words remain. A wrong role bit shows as the wrong slave giving `dtack_o` or `berr_o` on the first strobe that follows. Event-counter and status errors are visible on the next register read after a broadcast.

// File: rtl/cblt_pkg.sv
package cblt_pkg;

    localparam int DW = 64;
    localparam logic [5:0] AM_REG = 6'h2F;

    typedef enum logic [1:0] {
        CYC_NONE,
        CYC_REG,
        CYC_CHAIN,
        CYC_BCAST
    } cyc_e;

    // bit0 enable, bit1 first, bit2 last
    typedef struct packed {
        logic last;
        logic first;
        logic en;
    } role_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SKIP,
        S_REG,
        S_CB_WAIT,
        S_CB_OWN,
        S_CB_PASS,
        S_CB_END,
        S_MC_ARM,
        S_MC_TOK,
        S_MC_DONE
    } st_e;

    function automatic logic am_is_chain(input logic [5:0] am);
        return (am == 6'h0F) || (am == 6'h0B) || (am == 6'h0C) || (am == 6'h08);
    endfunction

    function automatic logic am_is_wide(input logic [5:0] am);
        return (am == 6'h0C) || (am == 6'h08);
    endfunction

    function automatic logic am_is_bcast(input logic [5:0] am);
        return (am == 6'h09) || (am == 6'h0D);
    endfunction

endpackage

// File: rtl/cblt_decode.sv
module cblt_decode
    import cblt_pkg::*;
#(
    parameter logic [7:0]  CHAIN_ADR = 8'hC0,
    parameter logic [7:0]  BCAST_ADR = 8'hB0,
    parameter logic [15:0] CSR_PAGE  = 16'h00C1
) (
    input  logic [5:0]  am_i,
    input  logic [31:0] addr_i,
    input  logic        write_i,
    output cyc_e        kind_o,
    output logic        wide_o,
    output logic [5:0]  reg_off_o
);
    logic reg_hit, chain_hit, bcast_hit;

    always_comb begin
        reg_hit   = (am_i == AM_REG) && (addr_i[23:8] == CSR_PAGE) && (addr_i[1:0] == 2'b00);
        chain_hit = am_is_chain(am_i) && (addr_i[31:24] == CHAIN_ADR) && !write_i;
        bcast_hit = am_is_bcast(am_i) && (addr_i[31:24] == BCAST_ADR) && write_i;
        if (reg_hit)        kind_o = CYC_REG;
        else if (chain_hit) kind_o = CYC_CHAIN;
        else if (bcast_hit) kind_o = CYC_BCAST;
        else                kind_o = CYC_NONE;
        wide_o    = am_is_wide(am_i);
        reg_off_o = addr_i[7:2];
    end
endmodule

// File: rtl/cblt_csr.sv
module cblt_csr
    import cblt_pkg::*;
#(
    parameter int STAT_W = 8,
    parameter int ECNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [5:0]        off_i,
    input  logic [31:0]       wdata_i,
    input  logic [STAT_W-1:0] stat_set_i,
    input  logic              adv_i,
    output role_t             role_o,
    output logic [STAT_W-1:0] stat_o,
    output logic [31:0]       rdata_o
);
    localparam int ROLE_W = $bits(role_t);

    role_t             role_q;
    logic [STAT_W-1:0] stat_q;
    logic [ECNT_W-1:0] ecnt_q;
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i[31:ROLE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            role_q <= '0;
            stat_q <= '0;
            ecnt_q <= '0;
        end else begin
            if (we_i && off_i == 6'd0) role_q <= role_t'(wdata_i[ROLE_W-1:0]);
            stat_q <= (adv_i ? '0 : stat_q) | stat_set_i;
            if (adv_i) ecnt_q <= ecnt_q + 1'b1;
        end
    end

    always_comb begin
        case (off_i)
            6'd0:    rdata_o = 32'(role_q);
            6'd1:    rdata_o = 32'(stat_q);
            6'd2:    rdata_o = 32'(ecnt_q);
            default: rdata_o = '0;
        endcase
    end

    assign role_o = role_q;
    assign stat_o = stat_q;
endmodule

// File: rtl/cblt_chain.sv
module cblt_chain
    import cblt_pkg::*;
#(
    parameter int WCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_i,
    input  logic              ds_i,
    input  logic              write_i,
    input  cyc_e              kind_i,
    input  logic              wide_i,
    input  role_t             role_i,
    input  logic              tok_in_i,
    input  logic [DW-1:0]     word_i,
    input  logic [WCNT_W-1:0] words_i,
    input  logic [31:0]       reg_rdata_i,
    output logic              dtack_o,
    output logic              berr_o,
    output logic              oe_o,
    output logic [DW-1:0]     rdata_o,
    output logic              tok_o,
    output logic              pop_o,
    output logic              adv_o,
    output logic              reg_we_o
);
    st_e           st_q;
    logic          dtack_q, berr_q, oe_q, tok_q, wide_q;
    logic [DW-1:0] rd_q;
    logic          have_tok, take, empty;

    always_comb begin
        have_tok = role_i.first || tok_in_i;
        empty    = (words_i == '0);
        take     = as_i && (st_q == S_CB_OWN) && ds_i && !dtack_q;
        pop_o    = take;
        adv_o    = as_i && (st_q == S_MC_ARM) && ds_i;
        reg_we_o = as_i && (st_q == S_REG) && ds_i && !dtack_q && write_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            dtack_q <= 1'b0;
            berr_q  <= 1'b0;
            oe_q    <= 1'b0;
            tok_q   <= 1'b0;
            wide_q  <= 1'b0;
            rd_q    <= '0;
        end else if (!as_i) begin
            st_q    <= S_IDLE;
            dtack_q <= 1'b0;
            berr_q  <= 1'b0;
            oe_q    <= 1'b0;
            tok_q   <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    wide_q <= wide_i;
                    case (kind_i)
                        CYC_REG:   st_q <= S_REG;
                        CYC_CHAIN: st_q <= role_i.en ? S_CB_WAIT : S_SKIP;
                        CYC_BCAST: st_q <= role_i.en ? S_MC_ARM : S_SKIP;
                        default:   st_q <= S_SKIP;
                    endcase
                end
                S_REG: begin
                    if (ds_i && !dtack_q) begin
                        dtack_q <= 1'b1;
                        if (!write_i) begin
                            oe_q <= 1'b1;
                            rd_q <= DW'(reg_rdata_i);
                        end
                    end else if (!ds_i) begin
                        dtack_q <= 1'b0;
                        oe_q    <= 1'b0;
                    end
                end
                S_CB_WAIT: begin
                    if (have_tok) begin
                        if (!empty)           st_q <= S_CB_OWN;
                        else if (role_i.last) st_q <= S_CB_END;
                        else begin
                            st_q  <= S_CB_PASS;
                            tok_q <= 1'b1;
                        end
                    end
                end
                S_CB_OWN: begin
                    if (take) begin
                        dtack_q <= 1'b1;
                        oe_q    <= 1'b1;
                        rd_q    <= wide_q ? word_i : {32'b0, word_i[31:0]};
                    end else if (!ds_i && dtack_q) begin
                        dtack_q <= 1'b0;
                        oe_q    <= 1'b0;
                        if (empty) begin
                            if (role_i.last) st_q <= S_CB_END;
                            else begin
                                st_q  <= S_CB_PASS;
                                tok_q <= 1'b1;
                            end
                        end
                    end
                end
                S_CB_END: begin
                    if (ds_i && !berr_q) berr_q <= 1'b1;
                    else if (!ds_i)      berr_q <= 1'b0;
                end
                S_MC_ARM: begin
                    if (ds_i) st_q <= S_MC_TOK;
                end
                S_MC_TOK: begin
                    if (have_tok) begin
                        tok_q <= 1'b1;
                        st_q  <= S_MC_DONE;
                        if (role_i.last) dtack_q <= 1'b1;
                    end
                end
                S_MC_DONE: begin
                    if (!ds_i) dtack_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign dtack_o = dtack_q;
    assign berr_o  = berr_q;
    assign oe_o    = oe_q;
    assign rdata_o = rd_q;
    assign tok_o   = tok_q;
endmodule

// File: rtl/cblt_slave.sv
module cblt_slave
    import cblt_pkg::*;
#(
    parameter logic [7:0]  CHAIN_ADR = 8'hC0,
    parameter logic [7:0]  BCAST_ADR = 8'hB0,
    parameter logic [15:0] CSR_PAGE  = 16'h00C1,
    parameter int          WCNT_W    = 12,
    parameter int          STAT_W    = 8,
    parameter int          ECNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_i,
    input  logic              ds_i,
    input  logic              write_i,
    input  logic [5:0]        am_i,
    input  logic [31:0]       addr_i,
    input  logic [31:0]       wdata_i,
    output logic [63:0]       rdata_o,
    output logic              rdata_oe_o,
    output logic              dtack_o,
    output logic              berr_o,
    input  logic              tok_in_i,
    output logic              tok_out_o,
    input  logic [63:0]       evt_word_i,
    input  logic [WCNT_W-1:0] evt_words_i,
    output logic              evt_pop_o,
    output logic              evt_next_o,
    input  logic [STAT_W-1:0] stat_set_i,
    output logic [STAT_W-1:0] stat_o
);
    cyc_e        kind;
    logic        wide;
    logic [5:0]  reg_off;
    role_t       role;
    logic [31:0] reg_rdata;
    logic        reg_we, adv, tok_own;

    cblt_decode #(
        .CHAIN_ADR(CHAIN_ADR),
        .BCAST_ADR(BCAST_ADR),
        .CSR_PAGE (CSR_PAGE)
    ) u_decode (
        .am_i     (am_i),
        .addr_i   (addr_i),
        .write_i  (write_i),
        .kind_o   (kind),
        .wide_o   (wide),
        .reg_off_o(reg_off)
    );

    cblt_csr #(
        .STAT_W(STAT_W),
        .ECNT_W(ECNT_W)
    ) u_csr (
        .clk       (clk),
        .rst       (rst),
        .we_i      (reg_we),
        .off_i     (reg_off),
        .wdata_i   (wdata_i),
        .stat_set_i(stat_set_i),
        .adv_i     (adv),
        .role_o    (role),
        .stat_o    (stat_o),
        .rdata_o   (reg_rdata)
    );

    cblt_chain #(
        .WCNT_W(WCNT_W)
    ) u_chain (
        .clk        (clk),
        .rst        (rst),
        .as_i       (as_i),
        .ds_i       (ds_i),
        .write_i    (write_i),
        .kind_i     (kind),
        .wide_i     (wide),
        .role_i     (role),
        .tok_in_i   (tok_in_i),
        .word_i     (evt_word_i),
        .words_i    (evt_words_i),
        .reg_rdata_i(reg_rdata),
        .dtack_o    (dtack_o),
        .berr_o     (berr_o),
        .oe_o       (rdata_oe_o),
        .rdata_o    (rdata_o),
        .tok_o      (tok_own),
        .pop_o      (evt_pop_o),
        .adv_o      (adv),
        .reg_we_o   (reg_we)
    );

    assign evt_next_o = adv;
    // A disabled slave is transparent to the token.
    assign tok_out_o  = role.en ? tok_own : tok_in_i;
endmodule

// File: rtl/cblt_slave_chk.sv
module cblt_slave_chk (
    input logic clk,
    input logic rst,
    input logic as_i,
    input logic ds_i,
    input logic dtack_o,
    input logic berr_o,
    input logic rdata_oe_o,
    input logic tok_out_o,
    input logic evt_pop_o,
    input logic evt_next_o,
    input logic role_en,
    input logic role_last
);
    assert_ack_or_err_R8: assert property (@(posedge clk) disable iff (rst)
        !(dtack_o && berr_o));

    assert_err_only_last_R8: assert property (@(posedge clk) disable iff (rst)
        berr_o |-> role_last);

    assert_pop_acks_R5: assert property (@(posedge clk) disable iff (rst)
        evt_pop_o |=> (dtack_o && rdata_oe_o));

    assert_ack_release_R5: assert property (@(posedge clk) disable iff (rst)
        (dtack_o && !ds_i && as_i) |=> !dtack_o);

    assert_as_drop_clears_R11: assert property (@(posedge clk) disable iff (rst)
        !as_i |=> (!dtack_o && !berr_o && !rdata_oe_o));

    assert_next_single_R9: assert property (@(posedge clk) disable iff (rst)
        evt_next_o |=> !evt_next_o);

    assert_passed_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (role_en && tok_out_o) |-> !rdata_oe_o);
endmodule

bind cblt_slave cblt_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .as_i      (as_i),
    .ds_i      (ds_i),
    .dtack_o   (dtack_o),
    .berr_o    (berr_o),
    .rdata_oe_o(rdata_oe_o),
    .tok_out_o (tok_out_o),
    .evt_pop_o (evt_pop_o),
    .evt_next_o(evt_next_o),
    .role_en   (role.en),
    .role_last (role.last)
);

// File: tb/cblt_slave_bench.sv
module cblt_slave_bench;
    localparam int WCNT_W = 12;
    localparam int STAT_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              as_i = 1'b0, ds_i = 1'b0, write_i = 1'b0;
    logic [5:0]        am_i = '0;
    logic [31:0]       addr_i = '0, wdata_i = '0;
    logic [63:0]       rdata_o;
    logic              rdata_oe_o, dtack_o, berr_o, tok_out_o;
    logic              tok_in_i = 1'b0;
    logic [63:0]       evt_word_i;
    logic [WCNT_W-1:0] words;
    logic [WCNT_W-1:0] next_words = '0;
    logic              evt_pop_o, evt_next_o;
    logic [STAT_W-1:0] stat_set_i = '0;
    logic [STAT_W-1:0] stat_o;

    int checks = 0, failures = 0;
    int n_pop = 0, n_next = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cblt_slave u_cblt_slave (
        .clk(clk), .rst(rst), .as_i(as_i), .ds_i(ds_i), .write_i(write_i),
        .am_i(am_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .rdata_oe_o(rdata_oe_o), .dtack_o(dtack_o), .berr_o(berr_o),
        .tok_in_i(tok_in_i), .tok_out_o(tok_out_o), .evt_word_i(evt_word_i),
        .evt_words_i(words), .evt_pop_o(evt_pop_o), .evt_next_o(evt_next_o),
        .stat_set_i(stat_set_i), .stat_o(stat_o)
    );

    function automatic logic [63:0] word_of(input logic [WCNT_W-1:0] n);
        return {16'hC0DE, 16'(n), 16'hBEEF, 16'(n)};
    endfunction

    // Event buffer model
    always @(posedge clk) begin
        if (rst || evt_next_o) words <= next_words;
        else if (evt_pop_o)    words <= words - 1'b1;
        if (!rst && evt_pop_o)  n_pop  <= n_pop + 1;
        if (!rst && evt_next_o) n_next <= n_next + 1;
    end
    assign evt_word_i = word_of(words);

    typedef struct packed {
        logic [5:0]  am;
        logic [31:0] addr;
        logic        we;
        logic [31:0] wd;
        logic        ack;
        logic [31:0] rd;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{6'h2F, 32'h0000_C100, 1'b1, 32'h0000_0005, 1'b1, 32'h0},
        '{6'h2F, 32'h0000_C100, 1'b0, 32'h0,         1'b1, 32'h5},
        '{6'h39, 32'h0000_C100, 1'b1, 32'h0000_0002, 1'b0, 32'h0},
        '{6'h2F, 32'h7F00_C100, 1'b0, 32'h0,         1'b1, 32'h5},
        '{6'h2F, 32'h0000_C200, 1'b1, 32'h0000_0002, 1'b0, 32'h0},
        '{6'h2F, 32'h0000_C100, 1'b0, 32'h0,         1'b1, 32'h5},
        '{6'h2F, 32'h0000_C108, 1'b0, 32'h0,         1'b1, 32'h0},
        '{6'h2F, 32'h0000_C100, 1'b1, 32'h0,         1'b1, 32'h0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_cyc(input logic [5:0] am, input logic [31:0] addr, input logic we,
                             input logic [31:0] wd);
        @(negedge clk);
        am_i = am; addr_i = addr; write_i = we; wdata_i = wd; as_i = 1'b1;
    endtask

    task automatic end_cyc();
        @(negedge clk);
        as_i = 1'b0; ds_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe(output logic ack, output logic err, output logic oe, output logic [63:0] d);
        ack = 1'b0; err = 1'b0; oe = 1'b0; d = '0;
        @(negedge clk);
        ds_i = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (dtack_o || berr_o) begin
                ack = dtack_o; err = berr_o; oe = rdata_oe_o; d = rdata_o;
                break;
            end
        end
        ds_i = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!dtack_o && !berr_o) break;
        end
    endtask

    task automatic reg_rw(input logic [5:0] am, input logic [31:0] addr, input logic we,
                          input logic [31:0] wd, output logic ack, output logic [63:0] d);
        logic e, o;
        start_cyc(am, addr, we, wd);
        strobe(ack, e, o, d);
        end_cyc();
    endtask

    task automatic set_role(input logic [2:0] r);
        logic a; logic [63:0] d;
        reg_rw(6'h2F, 32'h0000_C100, 1'b1, {29'b0, r}, a, d);
    endtask

    task automatic bcast(output logic ack);
        logic e, o; logic [63:0] d;
        start_cyc(6'h09, 32'hB000_0000, 1'b1, 32'h0);
        strobe(ack, e, o, d);
        end_cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic a, e, o;
        logic [63:0] d;
        int p0, n0, exp_evt;
        exp_evt = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!dtack_o && !berr_o && !rdata_oe_o, "R1 idle outputs", {dtack_o, berr_o, rdata_oe_o}, 0);
        tok_in_i = 1'b1; @(negedge clk);
        chk(tok_out_o == 1'b1, "R1 token follows", tok_out_o, 1);
        tok_in_i = 1'b0; @(negedge clk);
        chk(tok_out_o == 1'b0, "R1 token follows", tok_out_o, 0);
        reg_rw(6'h2F, 32'h0000_C100, 1'b0, 0, a, d);
        chk(a && d == 0, "R1 role reads zero", d, 0);

        // R2 register vector table
        foreach (VECS[i]) begin
            reg_rw(VECS[i].am, VECS[i].addr, VECS[i].we, VECS[i].wd, a, d);
            chk(a == VECS[i].ack, "R2 ack", a, VECS[i].ack);
            if (VECS[i].ack && !VECS[i].we)
                chk(d == {32'b0, VECS[i].rd}, "R2 read data", d, {32'b0, VECS[i].rd});
        end

        // R3 disabled slave (role now 0)
        next_words = 3;
        p0 = n_pop; n0 = n_next;
        start_cyc(6'h0C, 32'hC000_0000, 1'b0, 0);
        tok_in_i = 1'b1; @(negedge clk);
        chk(tok_out_o == 1'b1, "R3 token mirrors", tok_out_o, 1);
        tok_in_i = 1'b0; @(negedge clk);
        chk(tok_out_o == 1'b0, "R3 token mirrors", tok_out_o, 0);
        strobe(a, e, o, d);
        chk(!a && !e && n_pop == p0, "R3 chained ignored", {a, e}, 0);
        end_cyc();
        bcast(a);
        chk(!a && n_next == n0, "R3 broadcast ignored", n_next - n0, 0);

        // R10 / R9 broadcast as first, not last
        set_role(3'b011);
        n0 = n_next;
        start_cyc(6'h0D, 32'hB000_0000, 1'b1, 0);
        strobe(a, e, o, d);
        chk(!a, "R10 non-last no ack", a, 0);
        chk(tok_out_o == 1'b1, "R10 token passed", tok_out_o, 1);
        end_cyc();
        exp_evt++;
        chk(n_next == n0 + 1, "R9 one next pulse", n_next - n0, 1);

        // R5 R6 R7 D64 chained read of 3 words
        p0 = n_pop;
        start_cyc(6'h0C, 32'hC000_0000, 1'b0, 0);
        for (int k = 3; k >= 1; k--) begin
            strobe(a, e, o, d);
            chk(a && o && !e, "R5 word ack", {a, o, e}, 3'b110);
            chk(d == word_of(WCNT_W'(k)), "R6 wide word", d, word_of(WCNT_W'(k)));
        end
        chk(n_pop == p0 + 3, "R5 pops", n_pop - p0, 3);
        chk(tok_out_o == 1'b1, "R7 token after last word", tok_out_o, 1);
        strobe(a, e, o, d);
        chk(!a && !e && !rdata_oe_o, "R7 silent after pass", {a, e}, 0);
        end_cyc();
        chk(tok_out_o == 1'b0, "R11 token cleared", tok_out_o, 0);

        // R7 zero words
        next_words = 0;
        bcast(a); exp_evt++;
        start_cyc(6'h0F, 32'hC000_0000, 1'b0, 0);
        repeat (3) @(negedge clk);
        chk(tok_out_o && !rdata_oe_o, "R7 empty passes at once", {tok_out_o, rdata_oe_o}, 2'b10);
        end_cyc();

        // R11 abort and restart
        next_words = 4;
        bcast(a); exp_evt++;
        start_cyc(6'h0C, 32'hC000_0000, 1'b0, 0);
        strobe(a, e, o, d);
        chk(a && d == word_of(4), "R11 first word", d, word_of(4));
        end_cyc();
        chk(!dtack_o && !rdata_oe_o && !tok_out_o, "R11 as drop clears", {dtack_o, rdata_oe_o, tok_out_o}, 0);
        start_cyc(6'h0C, 32'hC000_0000, 1'b0, 0);
        strobe(a, e, o, d);
        chk(a && d == word_of(3), "R11 restart word", d, word_of(3));
        end_cyc();

        // R10 last slave broadcast waits for token
        set_role(3'b101);
        next_words = 2;
        n0 = n_next;
        start_cyc(6'h09, 32'hB000_0000, 1'b1, 0);
        @(negedge clk); ds_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(!dtack_o, "R10 last waits token", dtack_o, 0);
        chk(n_next == n0 + 1, "R9 next on strobe", n_next - n0, 1);
        tok_in_i = 1'b1;
        repeat (2) @(negedge clk);
        chk(dtack_o, "R10 last acks", dtack_o, 1);
        ds_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(!dtack_o, "R5 ack released", dtack_o, 0);
        end_cyc(); exp_evt++;
        tok_in_i = 1'b0;

        // R4 R6 R8 D32 read as last, not first
        start_cyc(6'h0B, 32'hC000_0000, 1'b0, 0);
        strobe(a, e, o, d);
        chk(!a && !e, "R4 waits token", {a, e}, 0);
        tok_in_i = 1'b1;
        strobe(a, e, o, d);
        chk(a && d == {32'b0, word_of(2)[31:0]}, "R6 narrow word", d, {32'b0, word_of(2)[31:0]});
        strobe(a, e, o, d);
        chk(a && d == {32'b0, word_of(1)[31:0]}, "R6 narrow word", d, {32'b0, word_of(1)[31:0]});
        strobe(a, e, o, d);
        chk(e && !a, "R8 bus error at end", {a, e}, 2'b01);
        end_cyc();

        // R9 status clear and event counter
        @(negedge clk); stat_set_i = 8'h5A;
        @(negedge clk); stat_set_i = '0;
        reg_rw(6'h2F, 32'h0000_C104, 1'b0, 0, a, d);
        chk(d == 64'h5A && stat_o == 8'h5A, "R2 status read", d, 64'h5A);
        next_words = 1;
        bcast(a); exp_evt++;
        chk(a, "R10 last acks broadcast", a, 1);
        chk(stat_o == 0, "R9 status cleared", stat_o, 0);
        reg_rw(6'h2F, 32'h0000_C108, 1'b0, 0, a, d);
        chk(d == 64'(exp_evt), "R9 event counter", d, 64'(exp_evt));
        tok_in_i = 1'b0;

        // R12 wrong direction
        set_role(3'b111);
        p0 = n_pop; n0 = n_next;
        start_cyc(6'h0F, 32'hC000_0000, 1'b1, 0);
        strobe(a, e, o, d);
        end_cyc();
        chk(!a && !e && n_pop == p0, "R12 chained write ignored", {a, e}, 0);
        start_cyc(6'h09, 32'hB000_0000, 1'b0, 0);
        strobe(a, e, o, d);
        end_cyc();
        chk(!a && n_next == n0, "R12 broadcast read ignored", n_next - n0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule